// File: doc/BRIEF.md
# Serial Memory Image Loader

This block fills a character storage array from a byte stream that comes in over a serial console link. The storage is a dual-port RAM. The processor keeps one port and uses it as its ordinary core storage, with synchronous reads and writes. The loader owns the second port, which only writes, so the processor's memory logic needs no change to accept a downloaded image.

A load begins with a one-cycle start pulse. After that, every byte that the receive path offers while the loader is busy is taken. Each byte has its two top bits exchanged to match the stored character layout and is written to the next address, starting at zero. When the configured image length has been written, the loader goes idle and gives a single-cycle completion pulse. Bytes that arrive after that point are left alone. While the loader is busy it holds the processor stopped. Once the load completes, the processor is expected to restart the image from location 1.

The image length `LOAD_LEN` is a parameter. A full-size machine sets it to 40000 characters, and the small defaults keep elaboration light. `LOAD_LEN` must not be larger than `MEM_DEPTH`.

Top module: `ser_image_loader`

## Requirements
- R1: While reset is held and just after it is released, `busy_o`, `done_o`, `cpu_hold_o` and `rx_ready_o` are all 0.
- R2: A high `start_i` in any cycle, including in the middle of a load, sets busy and resets the write address to 0, so the next byte accepted is stored at address 0. A byte offered in the same cycle as `start_i` is not accepted.
- R3: A byte is accepted on a rising edge only when `rx_valid_i` is 1, the loader is busy and `start_i` is 0. `rx_ready_o` shows exactly this condition without the valid term. A byte offered while idle changes no storage location.
- R4: Accepted bytes go to consecutive addresses 0, 1, 2, …, one address per accepted byte. Cycles without a valid byte do not move the address.
- R5: An incoming byte with bits [7:0] is stored with bit 7 = incoming bit 6 (check bit), bit 6 = incoming bit 7 (word mark), and bits 5..0 unchanged.
- R6: The edge that writes address `LOAD_LEN-1` clears busy. `done_o` is 1 for exactly the one cycle after that edge. Bytes offered afterwards are not written.
- R7: `cpu_hold_o` is 1 exactly while the loader is busy.
- R8: The processor port is synchronous. `cpu_rdata_o` after an edge holds the contents of `cpu_addr_i` as they were before that edge, and `cpu_we_i` writes `cpu_wdata_i` on that edge.
- R9: When the processor port and the loader write the same address on the same edge, the loader's byte is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins or restarts a load |
| rx_valid_i | input | 1 | The receive path has a byte available |
| rx_data_i | input | 8 | Received image byte |
| rx_ready_o | output | 1 | The loader will take a byte this cycle |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse after the final byte is written |
| cpu_hold_o | output | 1 | Keeps the processor stopped during a load |
| cpu_addr_i | input | AW | Processor port address |
| cpu_we_i | input | 1 | Processor port write enable |
| cpu_wdata_i | input | 8 | Processor port write data |
| cpu_rdata_o | output | 8 | Processor port read data, registered |

## Verification
The assertions assume three things about the inputs. The receive path presents each byte for a single accepted edge. `start_i` is a clean synchronous level. Processor addresses stay below `MEM_DEPTH`. The stimulus drives every input at the falling edge and holds processor addresses to the array range. It offers random bytes with random gaps, and it also offers bytes while the loader is idle, during the start pulse and after completion, so that each path through the acceptance rule is exercised.

// File: rtl/sil_pkg.sv
package sil_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;

  // Serial byte has word mark in bit 7 and check bit in bit 6;
  // storage wants them the other way round.
  function automatic logic [CHAR_W-1:0] remap_char(input logic [CHAR_W-1:0] b);
    return {b[6], b[7], b[5:0]};
  endfunction
endpackage

// File: rtl/sil_seq.sv
module sil_seq #(
  parameter int LOAD_LEN = 200,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          busy_o,
  output logic          done_o
);
  import sil_pkg::*;

  localparam int CW = $clog2(LOAD_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LOAD_LEN - 1);

  ld_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          take, at_last;

  assign rx_ready_o = (state_q == LD_RUN) && !start_i;
  assign take       = rx_ready_o && rx_valid_i;
  assign at_last    = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = LD_RUN;
      cnt_d   = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      if (at_last) begin
        state_d = LD_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign wr_en_o   = take;
  assign wr_addr_o = AW'(cnt_q);
  assign busy_o    = (state_q == LD_RUN);
  assign done_o    = done_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && at_last && !start_i) |=> (done_q && state_q == LD_IDLE));

  // R3
  write_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (state_q == LD_RUN && rx_valid_i && !start_i));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_o && !start_i) |=> $stable(cnt_q));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0 && state_q == LD_RUN));
endmodule

// File: rtl/sil_dpram.sv
module sil_dpram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr_i,
  input  logic          a_we_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  // Port B is written last so it wins on an address clash.
  always_ff @(posedge clk) begin
    if (a_we_i) mem[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[a_addr_i];
  end

  assign a_rdata_o = rd_q;

  // R8
  a_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_we_i |-> (int'(a_addr_i) < DEPTH));
endmodule

// File: rtl/ser_image_loader.sv
module ser_image_loader #(
  parameter int MEM_DEPTH = 256,
  parameter int LOAD_LEN  = 200,
  parameter int AW        = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          cpu_hold_o,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [7:0]    cpu_wdata_i,
  output logic [7:0]    cpu_rdata_o
);
  import sil_pkg::*;

  logic          ld_we;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  logic          busy;

  sil_seq #(.LOAD_LEN(LOAD_LEN), .AW(AW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rx_valid_i (rx_valid_i),
    .rx_ready_o (rx_ready_o),
    .wr_en_o    (ld_we),
    .wr_addr_o  (ld_addr),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  assign ld_data    = remap_char(rx_data_i);
  assign busy_o     = busy;
  assign cpu_hold_o = busy;

  sil_dpram #(.DEPTH(MEM_DEPTH), .AW(AW), .DW(CHAR_W)) ram_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_addr_i  (cpu_addr_i),
    .a_we_i    (cpu_we_i),
    .a_wdata_i (cpu_wdata_i),
    .a_rdata_o (cpu_rdata_o),
    .b_we_i    (ld_we),
    .b_addr_i  (ld_addr),
    .b_wdata_i (ld_data)
  );

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cpu_hold_o);

  // R3
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rx_ready_o);
endmodule

// File: tb/ser_image_loader_tb_top.sv
module ser_image_loader_tb_top;
  localparam int MEM_DEPTH = 256;
  localparam int LOAD_LEN  = 200;
  localparam int AW        = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, rx_valid_i, cpu_we_i;
  logic [7:0]    rx_data_i, cpu_wdata_i;
  logic [AW-1:0] cpu_addr_i;
  logic          rx_ready_o, busy_o, done_o, cpu_hold_o;
  logic [7:0]    cpu_rdata_o;

  always #10 clk = ~clk;

  ser_image_loader #(.MEM_DEPTH(MEM_DEPTH), .LOAD_LEN(LOAD_LEN), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o), .busy_o(busy_o),
    .done_o(done_o), .cpu_hold_o(cpu_hold_o), .cpu_addr_i(cpu_addr_i),
    .cpu_we_i(cpu_we_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] model [MEM_DEPTH];
  bit         known [MEM_DEPTH];
  bit         m_busy = 0;
  int         m_addr = 0;

  function automatic logic [7:0] swap_top(input logic [7:0] b);
    return {b[6], b[7], b[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check after the next falling edge.
  task automatic cyc(input bit st, input bit v, input logic [7:0] d, input bit we,
                     input int a, input logic [7:0] wd, input string rd_req);
    logic [7:0] exp_rd;
    bit         rd_known, exp_done;
    start_i = st; rx_valid_i = v; rx_data_i = d;
    cpu_we_i = we; cpu_addr_i = AW'(a); cpu_wdata_i = wd;
    #1;
    chk(rx_ready_o == (m_busy && !st), "R3 ready", rx_ready_o, m_busy && !st);
    exp_rd = model[a]; rd_known = known[a]; exp_done = 0;
    if (we) begin model[a] = wd; known[a] = 1; end
    if (st) begin
      m_busy = 1; m_addr = 0;
    end else if (v && m_busy) begin
      model[m_addr] = swap_top(d); known[m_addr] = 1;
      if (m_addr == LOAD_LEN - 1) begin m_busy = 0; exp_done = 1; end
      m_addr++;
    end
    @(negedge clk);
    chk(busy_o == m_busy, "R2/R6 busy", busy_o, m_busy);
    chk(cpu_hold_o == m_busy, "R7 hold", cpu_hold_o, m_busy);
    chk(done_o == exp_done, "R6 done", done_o, exp_done);
    if (rd_known) chk(cpu_rdata_o == exp_rd, rd_req, cpu_rdata_o, exp_rd);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_DEPTH; i++) begin known[i] = 0; model[i] = '0; end
    rst_n = 0; start_i = 0; rx_valid_i = 0; rx_data_i = 0;
    cpu_we_i = 0; cpu_addr_i = 0; cpu_wdata_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(cpu_hold_o == 0, "R1 hold", cpu_hold_o, 0);
    chk(rx_ready_o == 0, "R1 ready", rx_ready_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && cpu_hold_o == 0 && rx_ready_o == 0, "R1 after release",
        busy_o, 0);

    // R8: fill storage through the processor port
    for (int a = 0; a < MEM_DEPTH; a++)
      cyc(0, 0, 8'h00, 1, a, 8'($urandom), "R8 read");
    for (int a = 0; a < 8; a++)
      cyc(0, 0, 8'h00, 0, a, 8'h00, "R8 read");

    // R3: bytes offered while idle are ignored
    for (int k = 0; k < 6; k++) cyc(0, 1, 8'($urandom), 0, 0, 8'h00, "R3 idle");
    for (int a = 0; a < 8; a++) cyc(0, 0, 8'h00, 0, a, 8'h00, "R3 idle read");

    // Main load: random gaps, random processor reads, one clash
    cyc(0, 0, 8'h00, 0, 0, 8'h00, "R8 read");
    cyc(1, 1, 8'hC3, 0, 0, 8'h00, "R2 start");
    cyc(0, 1, 8'h80, 0, 0, 8'h00, "R5 read");   // word mark only
    cyc(0, 1, 8'h40, 0, 1, 8'h00, "R5 read");   // check bit only
    cyc(0, 1, 8'hFF, 0, 2, 8'h00, "R5 read");
    while (m_busy) begin
      if (m_addr == 60) begin
        // R9 clash on the loader's current address
        cyc(0, 1, 8'h9A, 1, m_addr, 8'h11, "R9 clash");
        cyc(0, 0, 8'h00, 0, m_addr - 1, 8'h00, "R9 read");
      end else begin
        cyc(0, ($urandom % 4) != 0, 8'($urandom), 0, $urandom % MEM_DEPTH, 8'h00,
            "R5 read");
      end
    end
    // R6: bytes after completion are not written
    for (int k = 0; k < 6; k++) cyc(0, 1, 8'($urandom), 0, 0, 8'h00, "R6 after");
    // R4 R5 R6: read every location back
    for (int a = 0; a < MEM_DEPTH; a++) cyc(0, 0, 8'h00, 0, a, 8'h00, "R4 readback");
    cyc(0, 0, 8'h00, 0, 0, 8'h00, "R4 readback");

    // R2: restart in the middle of a load
    cyc(1, 0, 8'h00, 0, 0, 8'h00, "R2 read");
    for (int k = 0; k < 3; k++) cyc(0, 1, 8'($urandom), 0, 0, 8'h00, "R2 read");
    cyc(1, 1, 8'h5A, 0, 0, 8'h00, "R2 restart");
    cyc(0, 1, 8'hA5, 0, 0, 8'h00, "R2 read");
    cyc(0, 1, 8'h3C, 0, 0, 8'h00, "R2 read");
    for (int a = 0; a < 5; a++) cyc(0, 0, 8'h00, 0, a, 8'h00, "R2 readback");
    cyc(0, 0, 8'h00, 0, 0, 8'h00, "R2 readback");
    chk(m_addr == 2, "R2 count", m_addr, 2);

    finish_run();
  end
endmodule